// File: doc/BRIEF.md
# DRAM Bank Precharge Timing Tracker

This block follows a four-bank DDR2-style command stream and keeps, for every bank, whether a row is open and how many cycles remain before a precharge or a new activate is legal. A memory controller's scheduler reads the per-bank `pre_ok_o` and `act_ok_o` flags to pick legal commands. The block does not issue commands itself. The only command it creates internally is the automatic precharge requested by a read or write with A10 set.

Timing values arrive as static configuration inputs, given as clock-cycle counts. Burst length is either 4 or 8. The read-to-precharge and write-to-precharge distances are derived from these values. Every precharge or activate that arrives too early raises a one-cycle violation pulse that names the bank involved. The offending command still updates the bank state.

Top module: `dram_pre_tracker`

## Requirements
- R1: Commands are coded on `cmd_i` as 00 activate, 01 read, 10 write, 11 precharge. A precharge with `a10_i` low closes only the bank selected by `bank_i` (0 to 3). The other banks are left open.
- R2: A precharge with `a10_i` high closes every bank, whatever value `bank_i` holds.
- R3: After a read, `pre_ok_o` of that bank goes high so that a precharge is legal AL + BL/2 + max(tRTP,2) − 2 cycles after the read. BL/2 is 2 when `cfg_bl8_i` is 0 and 4 when it is 1.
- R4: After a write, a precharge to that bank is legal WL + BL/2 + tWR cycles after the write.
- R5: After an activate, `pre_ok_o` of that bank stays low until tRAS cycles have passed since the activate.
- R6: After a bank is precharged, `act_ok_o` of that bank goes high so that an activate is legal tRP cycles after the precharge. `act_ok_o` is low while the bank is open.
- R7: A read or write with `a10_i` high closes the bank by itself. The close happens on the first cycle in which both the tRAS window and the read or write window have expired. tRP is counted from that close.
- R8: A read or write with `a10_i` low leaves the bank open for as long as no precharge arrives.
- R9: A later read or write to the same bank keeps the larger of the remaining precharge window and the new one.
- R10: An activate to a bank with `act_ok_o` low, or a precharge to an open bank with `pre_ok_o` low, sets `viol_o` for exactly the next cycle. `viol_bank_o` then holds the lowest offending bank. The command still takes effect.
- R11: After reset every bank is closed, all `pre_ok_o` and `act_ok_o` bits are 1, and `viol_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | A command is present this cycle |
| cmd_i | input | 2 | Command code (see R1) |
| bank_i | input | BANK_W | Bank address |
| a10_i | input | 1 | Address bit 10: all-bank precharge or auto-precharge |
| cfg_bl8_i | input | 1 | 1 selects burst length 8, 0 selects burst length 4 |
| cfg_al_i | input | CNT_W | Additive latency in cycles |
| cfg_wl_i | input | CNT_W | Write latency in cycles |
| cfg_rtp_i | input | CNT_W | tRTP in cycles |
| cfg_wr_i | input | CNT_W | tWR in cycles |
| cfg_ras_i | input | CNT_W | tRAS in cycles |
| cfg_rp_i | input | CNT_W | tRP in cycles |
| open_o | output | NB | A row is open, one bit per bank |
| pre_ok_o | output | NB | A precharge is legal now, one bit per bank |
| act_ok_o | output | NB | An activate is legal now, one bit per bank |
| viol_o | output | 1 | Spacing violation pulse |
| viol_bank_o | output | BANK_W | Bank that caused the violation |

## Verification
The bench uses the default parameters: two bank-address bits, so four banks, and 5-bit configuration counts. It sets AL=1, WL=2, tWR=3, tRAS=6 and tRP=3. tRTP is set to 3 and then to 1, so the max(tRTP,2) clamp is exercised. Both burst lengths are used. With these small values every window closes within a few cycles, so each of the following can be measured to the exact cycle: tRAS dominating an auto-precharge, a write window shadowing a later read, and an all-bank violation that names the lowest offending bank.

// File: rtl/dpt_pkg.sv
package dpt_pkg;
  typedef enum logic [1:0] {
    CMD_ACT = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10,
    CMD_PRE = 2'b11
  } dpt_cmd_e;
endpackage

// File: rtl/dpt_decode.sv
module dpt_decode import dpt_pkg::*; #(
  parameter int NB     = 4,
  parameter int BANK_W = 2,
  parameter int CNT_W  = 5,
  parameter int WIN_W  = 7
) (
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              a10_i,
  input  logic              cfg_bl8_i,
  input  logic [CNT_W-1:0]  cfg_al_i,
  input  logic [CNT_W-1:0]  cfg_wl_i,
  input  logic [CNT_W-1:0]  cfg_rtp_i,
  input  logic [CNT_W-1:0]  cfg_wr_i,
  output logic [NB-1:0]     act_hit_o,
  output logic [NB-1:0]     rw_hit_o,
  output logic [NB-1:0]     pre_hit_o,
  output logic              ap_o,
  output logic [WIN_W-1:0]  rw_win_o
);
  dpt_cmd_e   cmd;
  logic [WIN_W-1:0] half_bl, rtp_eff, rd_win, wr_win;

  assign cmd     = dpt_cmd_e'(cmd_i);
  assign half_bl = cfg_bl8_i ? WIN_W'(4) : WIN_W'(2);
  // tRTP is clamped to a minimum of two cycles
  assign rtp_eff = (cfg_rtp_i < CNT_W'(2)) ? WIN_W'(2) : WIN_W'(cfg_rtp_i);
  assign rd_win  = WIN_W'(cfg_al_i) + half_bl + rtp_eff - WIN_W'(2);
  assign wr_win  = WIN_W'(cfg_wl_i) + half_bl + WIN_W'(cfg_wr_i);
  assign rw_win_o = (cmd == CMD_WR) ? wr_win : rd_win;
  assign ap_o     = a10_i;

  for (genvar g = 0; g < NB; g++) begin : g_hit
    logic sel;
    assign sel          = (bank_i == BANK_W'(g));
    assign act_hit_o[g] = cmd_valid_i && (cmd == CMD_ACT) && sel;
    assign rw_hit_o[g]  = cmd_valid_i && ((cmd == CMD_RD) || (cmd == CMD_WR)) && sel;
    assign pre_hit_o[g] = cmd_valid_i && (cmd == CMD_PRE) && (a10_i || sel);
  end
endmodule

// File: rtl/dpt_bank.sv
module dpt_bank #(
  parameter int CNT_W = 5,
  parameter int WIN_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             ap_i,
  input  logic             pre_i,
  input  logic [WIN_W-1:0] rw_win_i,
  input  logic [CNT_W-1:0] ras_i,
  input  logic [CNT_W-1:0] rp_i,
  output logic             open_o,
  output logic             pre_ok_o,
  output logic             act_ok_o
);
  logic [WIN_W-1:0] pre_cnt_q, act_cnt_q, pre_dec, act_dec, rw_load;
  logic             open_q, ap_q, auto_fire;

  // A window of N cycles loads N-1: the counter reads zero N edges on
  function automatic logic [WIN_W-1:0] m1(input logic [WIN_W-1:0] v);
    return (v == '0) ? '0 : v - WIN_W'(1);
  endfunction

  assign pre_dec   = m1(pre_cnt_q);
  assign act_dec   = m1(act_cnt_q);
  assign rw_load   = m1(rw_win_i);
  assign auto_fire = ap_q && open_q && (pre_cnt_q == '0) && !(act_i || rw_i || pre_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_cnt_q <= '0;
      act_cnt_q <= '0;
      open_q    <= 1'b0;
      ap_q      <= 1'b0;
    end else begin
      pre_cnt_q <= pre_dec;
      act_cnt_q <= act_dec;
      if (act_i) begin
        open_q    <= 1'b1;
        ap_q      <= 1'b0;
        pre_cnt_q <= m1(WIN_W'(ras_i));
      end else if (rw_i) begin
        pre_cnt_q <= (pre_dec > rw_load) ? pre_dec : rw_load;
        if (ap_i) ap_q <= 1'b1;
      end else if (pre_i) begin
        ap_q <= 1'b0;
        if (open_q) begin
          open_q    <= 1'b0;
          act_cnt_q <= m1(WIN_W'(rp_i));
        end
      end else if (auto_fire) begin
        open_q    <= 1'b0;
        ap_q      <= 1'b0;
        act_cnt_q <= m1(WIN_W'(rp_i));
      end
    end
  end

  assign open_o   = open_q;
  assign pre_ok_o = !open_q || (pre_cnt_q == '0);
  assign act_ok_o = !open_q && (act_cnt_q == '0);
endmodule

// File: rtl/dpt_viol.sv
module dpt_viol #(
  parameter int NB     = 4,
  parameter int BANK_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     act_hit_i,
  input  logic [NB-1:0]     pre_hit_i,
  input  logic [NB-1:0]     act_ok_i,
  input  logic [NB-1:0]     pre_ok_i,
  output logic              viol_o,
  output logic [BANK_W-1:0] viol_bank_o
);
  logic [NB-1:0]     bad;
  logic [BANK_W-1:0] first;

  assign bad = (act_hit_i & ~act_ok_i) | (pre_hit_i & ~pre_ok_i);

  always_comb begin
    first = '0;
    for (int i = NB - 1; i >= 0; i--) begin
      if (bad[i]) first = BANK_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_o      <= 1'b0;
      viol_bank_o <= '0;
    end else begin
      viol_o <= |bad;
      if (|bad) viol_bank_o <= first;
    end
  end
endmodule

// File: rtl/dram_pre_tracker.sv
module dram_pre_tracker #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 5,
  localparam int NB    = 1 << BANK_W,
  localparam int WIN_W = CNT_W + 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              a10_i,
  input  logic              cfg_bl8_i,
  input  logic [CNT_W-1:0]  cfg_al_i,
  input  logic [CNT_W-1:0]  cfg_wl_i,
  input  logic [CNT_W-1:0]  cfg_rtp_i,
  input  logic [CNT_W-1:0]  cfg_wr_i,
  input  logic [CNT_W-1:0]  cfg_ras_i,
  input  logic [CNT_W-1:0]  cfg_rp_i,
  output logic [NB-1:0]     open_o,
  output logic [NB-1:0]     pre_ok_o,
  output logic [NB-1:0]     act_ok_o,
  output logic              viol_o,
  output logic [BANK_W-1:0] viol_bank_o
);
  logic [NB-1:0]    act_hit, rw_hit, pre_hit;
  logic             ap;
  logic [WIN_W-1:0] rw_win;

  dpt_decode #(.NB(NB), .BANK_W(BANK_W), .CNT_W(CNT_W), .WIN_W(WIN_W)) u_dec (
    .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i), .bank_i(bank_i), .a10_i(a10_i),
    .cfg_bl8_i(cfg_bl8_i), .cfg_al_i(cfg_al_i), .cfg_wl_i(cfg_wl_i),
    .cfg_rtp_i(cfg_rtp_i), .cfg_wr_i(cfg_wr_i),
    .act_hit_o(act_hit), .rw_hit_o(rw_hit), .pre_hit_o(pre_hit),
    .ap_o(ap), .rw_win_o(rw_win)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    dpt_bank #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_bank (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .act_i(act_hit[g]), .rw_i(rw_hit[g]), .ap_i(ap), .pre_i(pre_hit[g]),
      .rw_win_i(rw_win), .ras_i(cfg_ras_i), .rp_i(cfg_rp_i),
      .open_o(open_o[g]), .pre_ok_o(pre_ok_o[g]), .act_ok_o(act_ok_o[g])
    );
  end

  dpt_viol #(.NB(NB), .BANK_W(BANK_W)) u_viol (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .act_hit_i(act_hit), .pre_hit_i(pre_hit),
    .act_ok_i(act_ok_o), .pre_ok_i(pre_ok_o),
    .viol_o(viol_o), .viol_bank_o(viol_bank_o)
  );
endmodule

// File: rtl/dpt_checker.sv
module dpt_checker #(
  parameter int BANK_W = 2,
  parameter int CNT_W  = 5,
  parameter int NB     = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cmd_valid_i,
  input logic [1:0]        cmd_i,
  input logic [BANK_W-1:0] bank_i,
  input logic              a10_i,
  input logic [CNT_W-1:0]  cfg_ras_i,
  input logic [NB-1:0]     open_o,
  input logic [NB-1:0]     pre_ok_o,
  input logic [NB-1:0]     act_ok_o,
  input logic              viol_o,
  input logic [BANK_W-1:0] viol_bank_o
);
  assert_pre_all_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == 2'b11 && a10_i |=> open_o == '0);

  assert_viol_src_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_o |-> $past(cmd_valid_i));

  for (genvar g = 0; g < NB; g++) begin : g_chk
    assert_pre_one_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_i && cmd_i == 2'b11 && !a10_i && bank_i == BANK_W'(g) |=> !open_o[g]);

    assert_ras_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_i && cmd_i == 2'b00 && bank_i == BANK_W'(g) && cfg_ras_i > CNT_W'(1)
      |=> open_o[g] && !pre_ok_o[g]);

    assert_act_early_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmd_valid_i && cmd_i == 2'b00 && bank_i == BANK_W'(g) && !act_ok_o[g]
      |=> viol_o && viol_bank_o == BANK_W'(g));
  end
endmodule

bind dram_pre_tracker dpt_checker #(.BANK_W(BANK_W), .CNT_W(CNT_W), .NB(NB)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
  .bank_i(bank_i), .a10_i(a10_i), .cfg_ras_i(cfg_ras_i), .open_o(open_o),
  .pre_ok_o(pre_ok_o), .act_ok_o(act_ok_o), .viol_o(viol_o), .viol_bank_o(viol_bank_o)
);

// File: tb/dram_pre_tracker_tb.sv
module dram_pre_tracker_tb;
  localparam int BANK_W = 2;
  localparam int CNT_W  = 5;
  localparam int NB     = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic [BANK_W-1:0] bank = '0;
  logic a10 = 1'b0;
  logic bl8 = 1'b0;
  logic [CNT_W-1:0] al = 5'd1, wl = 5'd2, rtp = 5'd3, wr = 5'd3, ras = 5'd6, rp = 5'd3;
  logic [NB-1:0] open_w, pre_ok, act_ok;
  logic viol;
  logic [BANK_W-1:0] viol_bank;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  dram_pre_tracker #(.BANK_W(BANK_W), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .bank_i(bank),
    .a10_i(a10), .cfg_bl8_i(bl8), .cfg_al_i(al), .cfg_wl_i(wl), .cfg_rtp_i(rtp),
    .cfg_wr_i(wr), .cfg_ras_i(ras), .cfg_rp_i(rp), .open_o(open_w), .pre_ok_o(pre_ok),
    .act_ok_o(act_ok), .viol_o(viol), .viol_bank_o(viol_bank)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic issue(input logic [1:0] c, input int b, input logic a);
    cmd = c; bank = BANK_W'(b); a10 = a; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // spacing in cycles from the last command to the first edge where the flag allows a command
  task automatic wait_pre(input int b, output int sp);
    int n = 0;
    while (!pre_ok[b] && n < 200) begin @(negedge clk); n++; end
    sp = n + 1;
  endtask

  task automatic wait_act(input int b, output int sp);
    int n = 0;
    while (!act_ok[b] && n < 200) begin @(negedge clk); n++; end
    sp = n + 1;
  endtask

  task automatic wait_close(input int b, output int sp);
    int n = 0;
    while (open_w[b] && n < 200) begin @(negedge clk); n++; end
    sp = n;
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
    issue(2'b11, 0, 1'b1);
    repeat (10) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R11 open", int'(open_w), 0);
    chk("R11 pre_ok", int'(pre_ok), 15);
    chk("R11 act_ok", int'(act_ok), 15);
    chk("R11 viol", int'(viol), 0);
  endtask

  task automatic t_ras_rp();
    int sp;
    issue(2'b00, 0, 1'b0);
    wait_pre(0, sp);
    chk("R5 tRAS spacing", sp, 6);
    issue(2'b11, 0, 1'b0);
    chk("R10 legal pre no viol", int'(viol), 0);
    chk("R1 bank0 closed", int'(open_w[0]), 0);
    wait_act(0, sp);
    chk("R6 tRP spacing", sp, 3);
  endtask

  task automatic rd_case(input logic b8, input int t, input int exp, input string tag);
    int sp;
    bl8 = b8; rtp = CNT_W'(t);
    settle();
    issue(2'b00, 1, 1'b0);
    wait_pre(1, sp);
    issue(2'b01, 1, 1'b0);
    wait_pre(1, sp);
    chk(tag, sp, exp);
  endtask

  task automatic t_read();
    rd_case(1'b0, 3, 4, "R3 read bl4");
    rd_case(1'b1, 3, 6, "R3 read bl8");
    rd_case(1'b0, 1, 3, "R3 read rtp clamp");
    rtp = 5'd3; bl8 = 1'b0;
  endtask

  task automatic wr_case(input logic b8, input int exp, input string tag);
    int sp;
    bl8 = b8;
    settle();
    issue(2'b00, 2, 1'b0);
    wait_pre(2, sp);
    issue(2'b10, 2, 1'b0);
    wait_pre(2, sp);
    chk(tag, sp, exp);
  endtask

  task automatic t_write();
    wr_case(1'b0, 7, "R4 write bl4");
    wr_case(1'b1, 9, "R4 write bl8");
    bl8 = 1'b0;
  endtask

  task automatic t_auto();
    int sp;
    settle();
    issue(2'b00, 2, 1'b0);
    wait_pre(2, sp);
    issue(2'b01, 2, 1'b1);
    wait_act(2, sp);
    chk("R7 read ap act spacing", sp, 7);
    chk("R7 read ap closed", int'(open_w[2]), 0);
    settle();
    issue(2'b00, 2, 1'b0);
    wait_pre(2, sp);
    issue(2'b10, 2, 1'b1);
    wait_act(2, sp);
    chk("R7 write ap act spacing", sp, 10);
    settle();
    issue(2'b00, 3, 1'b0);
    issue(2'b01, 3, 1'b1);
    wait_close(3, sp);
    chk("R7 tRAS bound ap close", sp, 5);
  endtask

  task automatic t_open();
    settle();
    issue(2'b00, 1, 1'b0);
    repeat (8) @(negedge clk);
    issue(2'b01, 1, 1'b0);
    repeat (30) @(negedge clk);
    chk("R8 read stays open", int'(open_w[1]), 1);
    issue(2'b10, 1, 1'b0);
    repeat (30) @(negedge clk);
    chk("R8 write stays open", int'(open_w[1]), 1);
  endtask

  task automatic t_max();
    int sp;
    settle();
    issue(2'b00, 0, 1'b0);
    wait_pre(0, sp);
    issue(2'b10, 0, 1'b0);
    issue(2'b01, 0, 1'b0);
    wait_pre(0, sp);
    chk("R9 write window kept", sp, 6);
  endtask

  task automatic t_one_all();
    settle();
    issue(2'b00, 0, 1'b0);
    issue(2'b00, 2, 1'b0);
    repeat (10) @(negedge clk);
    issue(2'b11, 2, 1'b0);
    chk("R1 single bank close", int'(open_w), 1);
    settle();
    issue(2'b00, 0, 1'b0);
    issue(2'b00, 2, 1'b0);
    issue(2'b00, 3, 1'b0);
    repeat (10) @(negedge clk);
    issue(2'b11, 1, 1'b1);
    chk("R2 all banks closed", int'(open_w), 0);
    chk("R2 no viol", int'(viol), 0);
  endtask

  task automatic t_viol();
    int sp;
    settle();
    issue(2'b00, 1, 1'b0);
    issue(2'b11, 1, 1'b0);
    chk("R10 early pre viol", int'(viol), 1);
    chk("R10 early pre bank", int'(viol_bank), 1);
    chk("R10 still closed", int'(open_w[1]), 0);
    @(negedge clk);
    chk("R10 one cycle pulse", int'(viol), 0);
    issue(2'b00, 1, 1'b0);
    chk("R10 early act viol", int'(viol), 1);
    chk("R10 act still opens", int'(open_w[1]), 1);
    wait_pre(1, sp);
    issue(2'b00, 3, 1'b0);
    issue(2'b11, 0, 1'b1);
    chk("R10 all-bank viol", int'(viol), 1);
    chk("R10 all-bank viol bank", int'(viol_bank), 3);
    repeat (10) @(negedge clk);
    issue(2'b00, 3, 1'b0);
    repeat (10) @(negedge clk);
    issue(2'b00, 3, 1'b0);
    chk("R10 act open bank viol", int'(viol), 1);
    chk("R10 act open bank num", int'(viol_bank), 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ras_rp();
    t_read();
    t_write();
    t_auto();
    t_open();
    t_max();
    t_one_all();
    t_viol();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule